// File: doc/BRIEF.md
# Reconfigurable Phase-Shifted Carrier PWM for One Converter Arm

This block produces the switching commands for one arm of a modular multilevel converter that holds up to `N_MOD` series sub-modules. A single phase counter runs over one carrier period. Each active sub-module sees a triangular carrier taken from that counter at its own offset. The module's gate is asserted while its modulating value is above its carrier. The modulating values come from an upstream controller, and this block does not compute them.

A fault controller supplies a mask of healthy modules. When the mask changes, the block recomputes the carrier step for the new active count and the per-module capacitor voltage reference. It uses a pair of shared iterative dividers for this. The active modules are then re-ranked so that they sit evenly around the period, and removed modules are held in bypass. The new layout takes effect only where the carrier period wraps. The block enters a latched blocked state if more modules are unhealthy than the arm can tolerate. Only a reset clears that state.

Top module: `psc_arm_pwm`

## Requirements
- R1: After reset, all gate and bypass outputs are low and `blk_o` is low. `nact_o` equals `N_MOD`, `vref_o` equals `VREF_NOM`, and `vref_vld_o` is high.
- R2: The carrier of each module is a triangle that runs 0 up to `CMAX` and back, with period `2*CMAX` cycles. The gate is high when the module's 16-bit modulating value is strictly greater than the carrier. Over one period, a value m gives 0 high cycles for m=0, `2*m-1` high cycles for 1≤m≤`CMAX`, and the full period for m>`CMAX`.
- R3: An active module's rank k is the number of active modules with a lower index. Its carrier leads the rank-0 carrier by k·floor(2·`CMAX`/nact) cycles, where nact is the number of active modules.
- R4: A module whose mask bit is 0 has its bypass output high and its gate low, and it takes no rank.
- R5: Once a new mask has been applied, `nact_o` equals the number of ones in the mask.
- R6: `vref_o` becomes floor(`VREF_NOM`·`N_MOD`/nact). For example, 2250 becomes 3000 when 8 modules drop to 6. `vref_vld_o` is low from two cycles after a mask change until the new value is ready.
- R7: A new mask changes the active set only at a carrier period wrap, or at once while the carrier is disabled. `nact_o` therefore never changes in a cycle where it is not the first update after such a point.
- R8: When the number of zero mask bits exceeds `FAULT_MAX`, `blk_o` rises two cycles later and all gate and bypass outputs go low. This state persists through any later mask until reset. A count equal to `FAULT_MAX` does not block.
- R9: While `car_en_i` is low, the phase counter is held at zero and all gates are low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_en_i | input | 1 | Carrier run enable |
| act_mask_i | input | N_MOD | Healthy-module mask, bit i = module i usable |
| mod_i | input | N_MOD*CW | Modulating values, module i in bits [i*CW +: CW] |
| gate_o | output | N_MOD | Insert command per module |
| byp_o | output | N_MOD | Bypass command per module |
| blk_o | output | 1 | Arm blocked (all switches off), latched |
| nact_o | output | $clog2(N_MOD+1) | Number of modules in the applied active set |
| vref_o | output | RW | Scaled per-module capacitor voltage reference |
| vref_vld_o | output | 1 | `vref_o` holds the value for the latest mask |

## Verification
The bench builds the block with eight modules, `CMAX` = 120 (a 240-cycle period), a nominal reference of 2250 and a tolerance of two faults. With a period this short, every mask with at most two faults can be swept, 37 in all. For each mask the bench measures the rising-edge offsets and the high-cycle counts over one whole period. It also checks the dividers against the 2250, 2571 and 3000 cases. A mask with three faults exercises the latched block and its release by reset.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int MAXN = 32;

  typedef enum logic [1:0] {
    SLOT_OFF = 2'b00,
    SLOT_BYP = 2'b01,
    SLOT_INS = 2'b10
  } slot_e;

  function automatic int unsigned ones(input logic [MAXN-1:0] v);
    int unsigned c;
    c = 0;
    for (int k = 0; k < MAXN; k++) c = c + 32'(v[k]);
    return c;
  endfunction

endpackage

// File: rtl/psc_divider.sv
module psc_divider #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quo_o
);
  localparam int CNW = $clog2(DW + 1);

  logic [DW-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           busy_q, busy_d, done_q, done_d;
  logic [DW:0]    tmp;
  logic           ge;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    tmp    = {rem_q, quo_q[DW-1]};
    ge     = tmp >= {1'b0, dvs_q};
    if (start_i) begin
      rem_d  = '0;
      quo_d  = dvd_i;
      dvs_d  = (dvs_i == '0) ? DW'(1) : dvs_i;
      cnt_d  = CNW'(DW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? DW'(tmp - {1'b0, dvs_q}) : tmp[DW-1:0];
      quo_d = {quo_q[DW-2:0], ge};
      cnt_d = cnt_q - CNW'(1);
      if (cnt_q == CNW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= DW'(1);
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

endmodule

// File: rtl/psc_slot.sv
module psc_slot
  import psc_pkg::*;
#(
  parameter int CW   = 16,
  parameter int OW   = 9,
  parameter int PER  = 240,
  parameter int CMAX = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          act_i,
  input  logic          blk_i,
  input  logic [OW-1:0] ph_i,
  input  logic [OW-1:0] off_i,
  input  logic [CW-1:0] mod_i,
  output logic          gate_o,
  output logic          byp_o
);
  localparam int XW = (CW > OW) ? CW : OW;

  logic [OW-1:0] x_sum, x_wrap, car;
  logic [XW-1:0] car_x, mod_x;
  slot_e         st_q, st_d;

  always_comb begin
    x_sum  = ph_i + off_i;
    x_wrap = (x_sum >= OW'(PER)) ? x_sum - OW'(PER) : x_sum;
    car    = (x_wrap <= OW'(CMAX)) ? x_wrap : OW'(PER) - x_wrap;
    car_x  = XW'(car);
    mod_x  = XW'(mod_i);
    if (blk_i)                        st_d = SLOT_OFF;
    else if (!act_i)                  st_d = SLOT_BYP;
    else if (en_i && (mod_x > car_x)) st_d = SLOT_INS;
    else                              st_d = SLOT_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SLOT_OFF;
    else        st_q <= st_d;
  end

  assign gate_o = (st_q == SLOT_INS);
  assign byp_o  = (st_q == SLOT_BYP);

endmodule

// File: rtl/psc_arm_pwm.sv
module psc_arm_pwm
  import psc_pkg::*;
#(
  parameter int N_MOD     = 8,
  parameter int CW        = 16,
  parameter int CMAX      = 1000,
  parameter int RW        = 16,
  parameter int VREF_NOM  = 2250,
  parameter int FAULT_MAX = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          car_en_i,
  input  logic [N_MOD-1:0]              act_mask_i,
  input  logic [N_MOD*CW-1:0]           mod_i,
  output logic [N_MOD-1:0]              gate_o,
  output logic [N_MOD-1:0]              byp_o,
  output logic                          blk_o,
  output logic [$clog2(N_MOD+1)-1:0]    nact_o,
  output logic [RW-1:0]                 vref_o,
  output logic                          vref_vld_o
);
  localparam int PER   = 2 * CMAX;
  localparam int PW    = $clog2(PER);
  localparam int OW    = PW + 1;
  localparam int CNTW  = $clog2(N_MOD + 1);
  localparam int PROD  = VREF_NOM * N_MOD;
  localparam int PRW   = $clog2(PROD + 1);
  localparam int DW    = (PRW > OW) ? PRW : OW;
  localparam int STEP0 = PER / N_MOD;

  logic [N_MOD-1:0] mask_q, pend_q, pend_d, act_q, act_d;
  logic [OW-1:0]    step_q, step_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic [CNTW-1:0]  nact_q, nact_d, mask_cnt;
  logic [RW-1:0]    vref_q, vref_d;
  logic             vld_q, vld_d, rdy_q, rdy_d, blk_q, blk_d;
  logic             trip, start, apply;
  logic             busy_a, busy_b, done_a, done_b;
  logic [DW-1:0]    step_quo, ref_quo, dvs;

  assign mask_cnt = CNTW'(ones(MAXN'(mask_q)));
  assign dvs      = DW'(mask_cnt);

  psc_divider #(.DW(DW)) div_step_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dvd_i(DW'(PER)), .dvs_i(dvs),
    .busy_o(busy_a), .done_o(done_a), .quo_o(step_quo)
  );

  psc_divider #(.DW(DW)) div_ref_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dvd_i(DW'(PROD)), .dvs_i(dvs),
    .busy_o(busy_b), .done_o(done_b), .quo_o(ref_quo)
  );

  always_comb begin
    trip   = (int'(mask_cnt) + FAULT_MAX) < N_MOD;
    blk_d  = blk_q | trip;
    start  = !(busy_a | busy_b) && (mask_q != pend_q);
    apply  = rdy_q && (!car_en_i || (ph_q == PW'(PER - 1)));

    if (!car_en_i)                  ph_d = '0;
    else if (ph_q == PW'(PER - 1))  ph_d = '0;
    else                            ph_d = ph_q + PW'(1);

    pend_d = start ? mask_q : pend_q;

    if (start)                rdy_d = 1'b0;
    else if (done_a & done_b) rdy_d = 1'b1;
    else if (apply)           rdy_d = 1'b0;
    else                      rdy_d = rdy_q;

    act_d  = apply ? pend_q : act_q;
    step_d = apply ? step_quo[OW-1:0] : step_q;
    nact_d = CNTW'(ones(MAXN'(act_q)));

    vref_d = (done_a & done_b) ? RW'(ref_quo) : vref_q;
    if (start)                vld_d = 1'b0;
    else if (done_a & done_b) vld_d = 1'b1;
    else                      vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '1;
      act_q  <= '1;
      step_q <= OW'(STEP0);
      ph_q   <= '0;
      nact_q <= CNTW'(N_MOD);
      vref_q <= RW'(VREF_NOM);
      vld_q  <= 1'b1;
      rdy_q  <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      mask_q <= act_mask_i;
      pend_q <= pend_d;
      act_q  <= act_d;
      step_q <= step_d;
      ph_q   <= ph_d;
      nact_q <= nact_d;
      vref_q <= vref_d;
      vld_q  <= vld_d;
      rdy_q  <= rdy_d;
      blk_q  <= blk_d;
    end
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_slot
    localparam logic [MAXN-1:0] LOWM = (MAXN'(1) << i) - MAXN'(1);
    logic [CNTW-1:0] rank;
    logic [OW-1:0]   off;

    assign rank = CNTW'(ones(MAXN'(act_q) & LOWM));
    assign off  = OW'(rank * step_q);

    psc_slot #(.CW(CW), .OW(OW), .PER(PER), .CMAX(CMAX)) slot_i (
      .clk(clk), .rst_n(rst_n), .en_i(car_en_i), .act_i(act_q[i]),
      .blk_i(blk_d), .ph_i(OW'(ph_q)), .off_i(off),
      .mod_i(mod_i[i*CW +: CW]),
      .gate_o(gate_o[i]), .byp_o(byp_o[i])
    );
  end

  assign blk_o      = blk_q;
  assign nact_o     = nact_q;
  assign vref_o     = vref_q;
  assign vref_vld_o = vld_q;

endmodule

// File: rtl/psc_arm_pwm_chk.sv
module psc_arm_pwm_chk #(
  parameter int N_MOD = 8,
  parameter int PW    = 11,
  parameter int CNTW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             car_en_i,
  input logic [N_MOD-1:0] gate_o,
  input logic [N_MOD-1:0] byp_o,
  input logic             blk_o,
  input logic [CNTW-1:0]  nact_o,
  input logic [PW-1:0]    ph_q
);

  AST_BLK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_o |-> (gate_o == '0 && byp_o == '0)); // R8

  AST_BLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    blk_o |=> blk_o); // R8

  AST_NO_GATE_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o & byp_o) == '0); // R4

  AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !car_en_i |=> gate_o == '0); // R9

  AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nact_o) |-> $past(ph_q) == '0); // R7

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_o |-> ($countones(byp_o) + int'(nact_o)) == N_MOD); // R5

endmodule

bind psc_arm_pwm psc_arm_pwm_chk #(.N_MOD(N_MOD), .PW(PW), .CNTW(CNTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .car_en_i(car_en_i), .gate_o(gate_o),
  .byp_o(byp_o), .blk_o(blk_o), .nact_o(nact_o), .ph_q(ph_q)
);

// File: tb/psc_arm_pwm_tb_top.sv
module psc_arm_pwm_tb_top;
  localparam int N    = 8;
  localparam int CW   = 16;
  localparam int CMAX = 120;
  localparam int PER  = 2 * CMAX;
  localparam int VNOM = 2250;
  localparam int FMAX = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [N-1:0]  mask = '1;
  logic [N*CW-1:0] mods = '0;
  logic [N-1:0]  gate, byp;
  logic          blk;
  logic [3:0]    nact;
  logic [15:0]   vref;
  logic          vld;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  psc_arm_pwm #(.N_MOD(N), .CW(CW), .CMAX(CMAX), .RW(16), .VREF_NOM(VNOM),
                .FAULT_MAX(FMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .car_en_i(en), .act_mask_i(mask), .mod_i(mods),
    .gate_o(gate), .byp_o(byp), .blk_o(blk), .nact_o(nact), .vref_o(vref),
    .vref_vld_o(vld)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_mods(input int v);
    for (int i = 0; i < N; i++) mods[i*CW +: CW] = CW'(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en    = 1'b0;
    mask  = '1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  function automatic int duty(input int m);
    if (m == 0) return 0;
    if (m > CMAX) return PER;
    return 2 * m - 1;
  endfunction

  int t_rise[N];
  int hi_cnt[N];

  task automatic measure();
    logic [N-1:0] prev;
    for (int i = 0; i < N; i++) begin t_rise[i] = -1; hi_cnt[i] = 0; end
    prev = gate;
    for (int k = 1; k <= PER; k++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (gate[i]) hi_cnt[i]++;
        if (gate[i] && !prev[i]) t_rise[i] = k;
      end
      prev = gate;
    end
  endtask

  initial begin
    logic [N-1:0] cur;
    do_reset();
    // R1: reset state
    chk(gate == '0, "R1 gate after reset", int'(gate), 0);
    chk(byp == '0, "R1 bypass after reset", int'(byp), 0);
    chk(blk == 1'b0, "R1 blocked after reset", int'(blk), 0);
    chk(nact == 4'(N), "R1 active count after reset", int'(nact), N);
    chk(vref == 16'(VNOM), "R1 reference after reset", int'(vref), VNOM);
    chk(vld == 1'b1, "R1 reference valid after reset", int'(vld), 1);

    // R9: carrier disabled keeps gates low
    set_mods(16'hFFFF);
    tick(4);
    chk(gate == '0, "R9 gates with carrier disabled", int'(gate), 0);
    en = 1'b1;
    tick(3);
    chk(gate == '1, "R2 full value inserts all", int'(gate), 255);
    en = 1'b0;
    tick(2);
    chk(gate == '0, "R9 gates after disable", int'(gate), 0);
    en = 1'b1;

    // R2: duty over one period
    begin
      int vals[N] = '{0, 1, 2, 59, 60, 119, 120, 121};
      for (int i = 0; i < N; i++) mods[i*CW +: CW] = CW'(vals[i]);
      tick(4);
      measure();
      for (int i = 0; i < N; i++)
        chk(hi_cnt[i] == duty(vals[i]), "R2 high cycles per period", hi_cnt[i], duty(vals[i]));
    end

    // R3..R8: sweep all masks with tolerable fault counts
    set_mods(CMAX / 2);
    cur = '1;
    for (int m = 0; m < 256; m++) begin
      int na;
      int step;
      int ref_i;
      na = $countones(8'(m));
      if (N - na > FMAX) continue;
      mask = 8'(m);
      tick(2);
      if (8'(m) != cur) begin
        chk(vld == 1'b0, "R6 valid drops while recomputing", int'(vld), 0);
        chk(nact == 4'($countones(cur)), "R7 old set kept before wrap", int'(nact), $countones(cur));
      end
      cur = 8'(m);
      tick(2 * PER + 40);
      chk(nact == 4'(na), "R5 active count", int'(nact), na);
      chk(vld == 1'b1, "R6 reference valid", int'(vld), 1);
      chk(int'(vref) == (VNOM * N) / na, "R6 scaled reference", int'(vref), (VNOM * N) / na);
      chk(blk == 1'b0, "R8 fault count at limit does not block", int'(blk), 0);
      chk(byp == ~cur, "R4 bypass pattern", int'(byp), int'(~cur));
      measure();
      step  = PER / na;
      ref_i = -1;
      for (int i = 0; i < N; i++) if (cur[i] && ref_i < 0) ref_i = i;
      for (int i = 0; i < N; i++) begin
        if (cur[i]) begin
          int rk;
          int got;
          rk = 0;
          for (int j = 0; j < i; j++) if (cur[j]) rk++;
          got = (((t_rise[ref_i] - t_rise[i]) % PER) + PER) % PER;
          chk(t_rise[i] >= 0 && got == rk * step, "R3 carrier lead", got, rk * step);
        end else begin
          chk(hi_cnt[i] == 0, "R4 removed module never inserted", hi_cnt[i], 0);
        end
      end
    end

    // R8: exceeding the fault limit blocks, latched until reset
    set_mods(16'hFFFF);
    mask = 8'hE3;
    tick(3);
    chk(blk == 1'b1, "R8 block on three faults", int'(blk), 1);
    chk(gate == '0 && byp == '0, "R8 all outputs off when blocked", int'({gate, byp}), 0);
    mask = '1;
    tick(2 * PER + 40);
    chk(blk == 1'b1, "R8 block persists after mask recovers", int'(blk), 1);
    chk(gate == '0 && byp == '0, "R8 outputs stay off", int'({gate, byp}), 0);
    do_reset();
    chk(blk == 1'b0, "R8 reset clears block", int'(blk), 0);
    chk(nact == 4'(N), "R1 count after second reset", int'(nact), N);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule